// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that a synchronous DRAM core, or a model of one, steps through while it moves data. A request gives a starting column, a three-bit length code and an ordering bit. From the clock after the request onward, the block presents one column address per clock. A flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. Within that block they advance either by incrementing or by XOR-ing the beat number into the low address bits. The full-page length code walks the whole row, wrapping at its end, and keeps going until the controller ends it. Both stop and precharge indications reach the block on one stop input, which ends any burst early. A new request may arrive on any clock. It replaces whatever burst is in flight.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While reset is applied and after it is released with no request, `valid_o` and `last_o` are low.
- R2: In the clock after `start_i` is sampled high, `valid_o` is high and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: `len_code_i` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and the unused codes 3'b100 to 3'b110 give 1 beat.
- R4: With `interleave_i` low and a fixed length BL, beat n presents the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits stay unchanged.
- R5: With `interleave_i` high and BL of 2, 4 or 8, beat n presents the start column with its low log2(BL) bits XOR-ed with n.
- R6: Code 3'b111 selects full page. Beat n presents (start + n) mod 2^COL_W (256 by default), `interleave_i` has no effect, and the burst continues until a stop or a new start.
- R7: `last_o` is high only on the final beat of a fixed-length burst and never during a full-page burst. In the clock after the final beat, `valid_o` is low unless a new start was sampled.
- R8: When `stop_i` is sampled high while a beat is presented, that beat is the final one, and `valid_o` is low in the next clock.
- R9: When `start_i` is sampled high during a burst, the old burst is abandoned and the new burst's beat 0 appears in the next clock. `start_i` takes priority over `stop_i` sampled in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begins a new burst with the values below |
| start_col_i | input | COL_W | Starting column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved order, 0 sequential |
| stop_i | input | 1 | Ends the current burst after the beat now shown |
| valid_o | output | 1 | A column address is presented this clock |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench sweeps every starting column under every fixed length and both orderings. This exposes a generator that lets the carry escape the aligned block (sequential start at 7 with BL8 must return to 0, not reach 8), that adds instead of XOR-ing in interleaved mode, or that flags the last beat one clock off. Full-page bursts are run past the top of the row, where an address that fails to wrap, or an interleave bit that leaks in, shows up at once. Early stops, restarts in mid-burst, a start and a stop sampled together, and the unused length codes are also driven. A design that kept the old burst, let stop override start, or ran the wrong number of beats for a spare code would present a wrong column or a wrong `valid_o`.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  localparam int LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } len_code_e;

endpackage

// File: rtl/sdr_burst_cfg.sv
module sdr_burst_cfg
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_req_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o,
  output logic                  ilv_o
);

  always_comb begin
    full_o = 1'b0;
    mask_o = '0;
    case (code_i)
      LEN_TWO:   mask_o = COL_W'(1);
      LEN_FOUR:  mask_o = COL_W'(3);
      LEN_EIGHT: mask_o = COL_W'(7);
      LEN_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:   mask_o = '0;
    endcase
    ilv_o = ilv_req_i & ~full_o;
  end

endmodule

// File: rtl/sdr_burst_addr.sv
module sdr_burst_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (ilv_i)  col_o[b] = base_i[b] ^ beat_i[b];
      else             col_o[b] = sum[b];
    end
  end

endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);

  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, mask_q;
  logic             full_q, ilv_q;
  logic             cfg_en;
  logic             last;

  assign last   = active_q & ~full_q & (beat_q == mask_q);
  assign cfg_en = start_i;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (start_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (active_q && (stop_i || last)) begin
      active_d = 1'b0;
    end else if (active_q) begin
      beat_d = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (cfg_en) begin
      base_q <= col_i;
      mask_q <= mask_i;
      full_q <= full_i;
      ilv_q  <= ilv_i;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign ilv_o    = ilv_q;

  // R9
  restart_beat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && beat_q == '0));

  // R6
  page_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && full_q && !start_i && !stop_i) |=> active_q);

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  interleave_i,
  input  logic                  stop_i,
  output logic                  valid_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  last_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [COL_W-1:0] req_mask;
  logic             req_full, req_ilv;
  logic             active, last;
  logic [COL_W-1:0] base, beat, mask;
  logic             full, ilv;
  logic [COL_W-1:0] addr;

  sdr_burst_cfg #(.COL_W(COL_W)) u_cfg (
    .code_i    (len_code_i),
    .ilv_req_i (interleave_i),
    .mask_o    (req_mask),
    .full_o    (req_full),
    .ilv_o     (req_ilv)
  );

  sdr_burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .col_i    (start_col_i),
    .mask_i   (req_mask),
    .full_i   (req_full),
    .ilv_i    (req_ilv),
    .active_o (active),
    .last_o   (last),
    .base_o   (base),
    .beat_o   (beat),
    .mask_o   (mask),
    .full_o   (full),
    .ilv_o    (ilv)
  );

  sdr_burst_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (addr)
  );

  assign valid_o = active;
  assign last_o  = last;
  assign col_o   = active ? addr : '0;

  // R2
  first_beat_col_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R7
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (last_o && !start_i) |=> !valid_o);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  // R6
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && full && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1)));

  // R7
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && full) |-> !last_o);

  // R4
  upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && !last_o && !start_i && !stop_i)
      |=> (((col_o ^ $past(col_o)) & ~mask) == '0));

endmodule

// File: tb/tb_sdr_burst_colgen.sv
module tb_sdr_burst_colgen;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             valid_o;
  logic [COL_W-1:0] col_o;
  logic             last_o;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  sdr_burst_colgen #(.COL_W(COL_W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .stop_i       (stop_i),
    .valid_o      (valid_o),
    .col_o        (col_o),
    .last_o       (last_o)
  );

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [2:0] code, input logic ilv,
                                               input logic [COL_W-1:0] s, input int n);
    int bl = blen(code);
    logic [COL_W-1:0] m = COL_W'(bl - 1);
    if (ilv && code != 3'b111) return s ^ COL_W'(n);
    return (s & ~m) | ((s + COL_W'(n)) & m);
  endfunction

  task automatic check(input string req, input logic [COL_W-1:0] act_c, input logic act_v,
                       input logic act_l, input logic [COL_W-1:0] exp_c, input logic exp_v,
                       input logic exp_l);
    vectors++;
    if (act_v !== exp_v || act_l !== exp_l || (exp_v && act_c !== exp_c)) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b col=%0d last=%0b, expected valid=%0b col=%0d last=%0b",
               req, act_v, act_c, act_l, exp_v, exp_c, exp_l);
    end
  endtask

  // Drives one burst; stop_at < 0 means run to the natural end.
  task automatic run_burst(input logic [2:0] code, input logic ilv,
                           input logic [COL_W-1:0] s, input int stop_at, input string req);
    int  n = 0;
    bit  done = 0;
    logic el;
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; len_code_i = code; interleave_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
    while (!done) begin
      el = (code != 3'b111) && (n == blen(code) - 1);
      check(req, col_o, valid_o, last_o, exp_col(code, ilv, s, n), 1'b1, el);
      if (n == stop_at) stop_i = 1'b1;
      if (n == stop_at || el) done = 1;
      else begin
        n++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    stop_i = 1'b0;
    check({req, " end"}, col_o, valid_o, last_o, '0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", col_o, valid_o, last_o, '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", col_o, valid_o, last_o, '0, 1'b0, 1'b0);

    // R2 R3 R4 R5 R7: every start column, fixed lengths, both orders
    for (int c = 0; c < 4; c++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 256; s++)
          run_burst(3'(c), il[0], 8'(s), -1, il ? "R5" : "R4");

    // R3 spare codes behave as one beat
    for (int c = 4; c < 7; c++)
      for (int s = 0; s < 256; s += 37)
        run_burst(3'(c), 1'b0, 8'(s), -1, "R3");

    // R6 full page, wraps past the row end, interleave ignored
    run_burst(3'b111, 1'b0, 8'd250, 20, "R6");
    run_burst(3'b111, 1'b1, 8'd3, 300, "R6");
    run_burst(3'b111, 1'b0, 8'd0, 0, "R6");

    // R8 early stop in fixed bursts
    run_burst(3'b011, 1'b0, 8'd13, 2, "R8");
    run_burst(3'b011, 1'b1, 8'd6, 0, "R8");
    run_burst(3'b010, 1'b0, 8'd255, 1, "R8");

    // R9 restart mid-burst, start beating stop
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'd5; len_code_i = 3'b011; interleave_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check("R9", col_o, valid_o, last_o, 8'd5, 1'b1, 1'b0);
    @(negedge clk);
    check("R9", col_o, valid_o, last_o, 8'd6, 1'b1, 1'b0);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'h42; len_code_i = 3'b010; interleave_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check("R9", col_o, valid_o, last_o, 8'h42 ^ 8'(n), 1'b1, n == 3);
      @(negedge clk);
    end
    check("R9", col_o, valid_o, last_o, '0, 1'b0, 1'b0);

    // R9 back-to-back starts on consecutive clocks
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'd100; len_code_i = 3'b111; interleave_i = 1'b0;
    @(negedge clk);
    start_col_i = 8'd17; len_code_i = 3'b000;
    check("R9", col_o, valid_o, last_o, 8'd100, 1'b1, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    check("R9", col_o, valid_o, last_o, 8'd17, 1'b1, 1'b1);
    @(negedge clk);
    check("R7", col_o, valid_o, last_o, '0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule